// File: doc/BRIEF.md
# Serial-Bus Interrupt and DMA Arbiter

This block is the request logic of a byte-oriented serial bus peripheral. It turns the peripheral's events into one interrupt request and two DMA requests. The events are an error condition (any of a set of error flags), a byte received, a receive end-of-block, ready to transmit and a transmit end-of-block. It keeps one 8-bit status register that software reads and writes. The register holds a mode bit, a 3-bit priority level and three sticky pending bits: error, receive and transmit.

Each pending bit is served either by the CPU interrupt or, when the matching DMA enable is high, by a DMA request. A single arbiter picks one winner per cycle out of five candidates. The mode bit sets how errors and DMA interact. In suspended mode an outstanding error stops all DMA and is served first. In not-suspended mode DMA ignores errors and comes before every interrupt. Software clears pending bits by writing 0. The error bit cannot be cleared while an enabled error flag is still present.

Top module: `sbus_irq_arbiter`

## Requirements
- R1: After reset the register reads 0x80: mode 1 (not-suspended), level 0, all pending bits 0. No request output is active.
- R2: Register fields are: bit 7 mode, bits 6:4 priority level, bit 3 reserved, bit 2 error pending, bit 1 receive pending, bit 0 transmit pending. A write loads mode and level. Bit 3 always reads 0 and a write to it has no effect.
- R3: A write with 0 in a pending bit position clears that bit. A write with 1 there leaves it unchanged and never sets it.
- R4: Pending bits are set only while irq_enable is 1. Error pending is set by any asserted err_flags bit. Receive pending is set by rx_data_evt or rx_eob_evt. Transmit pending is set by tx_ready_evt or tx_eob_evt. With irq_enable at 0, no event sets any bit.
- R5: If an event sets a pending bit in the same cycle that a write clears it, the bit ends up 1.
- R6: While irq_enable is 1 and any err_flags bit is 1, error pending stays 1 and a write of 0 to it has no effect.
- R7: In suspended mode (mode 0), no DMA request is issued while error pending is 1. The winner order is error, receive DMA, transmit DMA, receive interrupt, transmit interrupt.
- R8: In not-suspended mode (mode 1), error pending has no effect on DMA. The winner order is receive DMA, transmit DMA, error, receive interrupt, transmit interrupt.
- R9: Receive DMA is a candidate when rx_dma_en and receive pending are both 1. Transmit DMA is a candidate when tx_dma_en and transmit pending are both 1. A receive or transmit pending bit whose DMA enable is 1 is never an interrupt candidate. Only the single winner drives its output.
- R10: irq_level always shows the level field. When the winner is an interrupt source and the level is 7, irq_req stays 0. The level does not affect DMA requests.
- R11: irq_src is 00 when irq_req is 0. Otherwise it is 01 for error, 10 for receive and 11 for transmit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Status register write strobe |
| reg_wr_data | input | 8 | Status register write data |
| reg_rd_data | output | 8 | Status register read value |
| err_flags | input | ERR_W | Error condition flags from the protocol engine |
| rx_data_evt | input | 1 | Byte received event |
| rx_eob_evt | input | 1 | Receive end-of-block event |
| tx_ready_evt | input | 1 | Ready-to-transmit event |
| tx_eob_evt | input | 1 | Transmit end-of-block event |
| irq_enable | input | 1 | Interrupt enable; gates setting of pending bits |
| rx_dma_en | input | 1 | Serve receive pending by DMA |
| tx_dma_en | input | 1 | Serve transmit pending by DMA |
| irq_req | output | 1 | Interrupt request to the CPU |
| irq_level | output | 3 | Priority level of the request |
| irq_src | output | 2 | Winning interrupt source code |
| rx_dma_req | output | 1 | Receive DMA request |
| tx_dma_req | output | 1 | Transmit DMA request |

## Verification
The bench drives random write, event and flag mixes in both modes and compares every cycle against a reference model. This catches a reversed rank order, for example an error interrupt hiding a receive DMA in not-suspended mode, or DMA leaking through an error in suspended mode. Directed cases cover these:
- A set event and a clear write on the same edge; a design where the clear wins drops the event.
- A clear of error pending while a flag is still high; a design that lets the clear through loses the error.
- A write of 1 to a clear bit; a design that treats 1 as a set raises a false interrupt.
- Level 7 with sources pending; a design that ignores the level still interrupts the CPU.

// File: rtl/sbus_irq_pkg.sv
package sbus_irq_pkg;

  localparam int REG_W    = 8;
  localparam int LEVEL_W  = 3;
  localparam int NPEND    = 3;
  localparam int BIT_MODE = 7;
  localparam int BIT_RSVD = 3;
  localparam int BIT_ERR  = 2;
  localparam int BIT_RX   = 1;
  localparam int BIT_TX   = 0;
  localparam logic [LEVEL_W-1:0] LEVEL_MUTE = '1;

  typedef enum logic [2:0] {
    SRC_NONE,
    SRC_ERR,
    SRC_RXDMA,
    SRC_TXDMA,
    SRC_RXIRQ,
    SRC_TXIRQ
  } src_e;

  typedef struct packed {
    logic err;
    logic rxdma;
    logic txdma;
    logic rxirq;
    logic txirq;
  } cand_t;

  // Fixed-order pick; mode 0 puts the error first, mode 1 puts DMA first.
  function automatic src_e arb_pick(input logic not_susp, input cand_t c);
    src_e w;
    w = SRC_NONE;
    if (!not_susp && c.err) w = SRC_ERR;
    else if (c.rxdma)       w = SRC_RXDMA;
    else if (c.txdma)       w = SRC_TXDMA;
    else if (c.err)         w = SRC_ERR;
    else if (c.rxirq)       w = SRC_RXIRQ;
    else if (c.txirq)       w = SRC_TXIRQ;
    return w;
  endfunction

  function automatic logic is_irq_src(input src_e s);
    return (s == SRC_ERR) || (s == SRC_RXIRQ) || (s == SRC_TXIRQ);
  endfunction

  function automatic logic [1:0] src_code(input src_e s);
    logic [1:0] c;
    case (s)
      SRC_ERR:   c = 2'b01;
      SRC_RXIRQ: c = 2'b10;
      SRC_TXIRQ: c = 2'b11;
      default:   c = 2'b00;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/sbus_irq_events.sv
module sbus_irq_events #(
  parameter int ERR_W = 8
) (
  input  logic                           irq_enable,
  input  logic [ERR_W-1:0]               err_flags,
  input  logic                           rx_data_evt,
  input  logic                           rx_eob_evt,
  input  logic                           tx_ready_evt,
  input  logic                           tx_eob_evt,
  output logic [sbus_irq_pkg::NPEND-1:0] set_vec
);
  import sbus_irq_pkg::*;

  logic err_any;
  logic rx_any;
  logic tx_any;

  assign err_any = |err_flags;
  assign rx_any  = rx_data_evt | rx_eob_evt;
  assign tx_any  = tx_ready_evt | tx_eob_evt;

  // A set request that persists each cycle also holds the error bit high.
  always_comb begin
    set_vec         = '0;
    set_vec[BIT_ERR] = irq_enable & err_any;
    set_vec[BIT_RX]  = irq_enable & rx_any;
    set_vec[BIT_TX]  = irq_enable & tx_any;
  end

  always_comb begin
    if (!irq_enable) a_gate_r4: assert (set_vec == '0);
  end

endmodule

// File: rtl/sbus_irq_status_reg.sv
module sbus_irq_status_reg (
  input  logic                                    clk,
  input  logic                                    rst_n,
  input  logic                                    wr_en,
  input  logic [sbus_irq_pkg::REG_W-1:0]          wr_data,
  input  logic [sbus_irq_pkg::NPEND-1:0]          set_vec,
  output logic                                    mode_q,
  output logic [sbus_irq_pkg::LEVEL_W-1:0]        level_q,
  output logic [sbus_irq_pkg::NPEND-1:0]          pend_q,
  output logic [sbus_irq_pkg::REG_W-1:0]          rd_data
);
  import sbus_irq_pkg::*;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q  <= 1'b1;
      level_q <= '0;
    end else if (wr_en) begin
      mode_q  <= wr_data[BIT_MODE];
      level_q <= wr_data[BIT_MODE-1 -: LEVEL_W];
    end
  end

  for (genvar i = 0; i < NPEND; i++) begin : g_pend
    logic bit_q;
    logic clr;
    assign clr = wr_en & ~wr_data[i];
    always_ff @(posedge clk) begin
      if (!rst_n)          bit_q <= 1'b0;
      else if (set_vec[i]) bit_q <= 1'b1;
      else if (clr)        bit_q <= 1'b0;
    end
    assign pend_q[i] = bit_q;

    p_set_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
      set_vec[i] |=> bit_q);
    p_one_never_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!bit_q && !set_vec[i]) |=> !bit_q);
    p_zero_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && !set_vec[i]) |=> !bit_q);
  end

  assign rd_data = {mode_q, level_q, 1'b0, pend_q};

  always_comb begin
    a_rsvd_zero_r2: assert (rd_data[BIT_RSVD] == 1'b0);
  end

endmodule

// File: rtl/sbus_irq_prio_arb.sv
module sbus_irq_prio_arb (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              not_susp,
  input  logic [sbus_irq_pkg::LEVEL_W-1:0]  level,
  input  logic [sbus_irq_pkg::NPEND-1:0]    pend,
  input  logic                              rx_dma_en,
  input  logic                              tx_dma_en,
  output logic                              irq_req,
  output logic [1:0]                        irq_src,
  output logic                              rx_dma_req,
  output logic                              tx_dma_req
);
  import sbus_irq_pkg::*;

  cand_t cand;
  src_e  winner;
  logic  dma_allowed;
  logic  win_is_irq;

  assign dma_allowed = not_susp | ~pend[BIT_ERR];

  always_comb begin
    cand.err   = pend[BIT_ERR];
    cand.rxdma = rx_dma_en & pend[BIT_RX] & dma_allowed;
    cand.txdma = tx_dma_en & pend[BIT_TX] & dma_allowed;
    cand.rxirq = ~rx_dma_en & pend[BIT_RX];
    cand.txirq = ~tx_dma_en & pend[BIT_TX];
  end

  assign winner     = arb_pick(not_susp, cand);
  assign win_is_irq = is_irq_src(winner);
  assign irq_req    = win_is_irq & (level != LEVEL_MUTE);
  assign irq_src    = irq_req ? src_code(winner) : 2'b00;
  assign rx_dma_req = (winner == SRC_RXDMA);
  assign tx_dma_req = (winner == SRC_TXDMA);

  p_susp_blocks_dma_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!not_susp && pend[BIT_ERR]) |-> (!rx_dma_req && !tx_dma_req));
  p_dma_over_err_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (not_susp && rx_dma_en && pend[BIT_RX]) |-> (rx_dma_req && !irq_req));
  p_single_winner_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({irq_req, rx_dma_req, tx_dma_req}));
  p_mute_level_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (level == LEVEL_MUTE) |-> !irq_req);
  p_src_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_req |-> (irq_src == 2'b00));

endmodule

// File: rtl/sbus_irq_arbiter.sv
module sbus_irq_arbiter #(
  parameter int ERR_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr_en,
  input  logic [7:0]       reg_wr_data,
  output logic [7:0]       reg_rd_data,
  input  logic [ERR_W-1:0] err_flags,
  input  logic             rx_data_evt,
  input  logic             rx_eob_evt,
  input  logic             tx_ready_evt,
  input  logic             tx_eob_evt,
  input  logic             irq_enable,
  input  logic             rx_dma_en,
  input  logic             tx_dma_en,
  output logic             irq_req,
  output logic [2:0]       irq_level,
  output logic [1:0]       irq_src,
  output logic             rx_dma_req,
  output logic             tx_dma_req
);
  import sbus_irq_pkg::*;

  logic [NPEND-1:0]   set_vec;
  logic [NPEND-1:0]   pend_q;
  logic               mode_q;
  logic [LEVEL_W-1:0] level_q;

  sbus_irq_events #(.ERR_W(ERR_W)) u_events (
    .irq_enable  (irq_enable),
    .err_flags   (err_flags),
    .rx_data_evt (rx_data_evt),
    .rx_eob_evt  (rx_eob_evt),
    .tx_ready_evt(tx_ready_evt),
    .tx_eob_evt  (tx_eob_evt),
    .set_vec     (set_vec)
  );

  sbus_irq_status_reg u_reg (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (reg_wr_en),
    .wr_data(reg_wr_data),
    .set_vec(set_vec),
    .mode_q (mode_q),
    .level_q(level_q),
    .pend_q (pend_q),
    .rd_data(reg_rd_data)
  );

  sbus_irq_prio_arb u_arb (
    .clk       (clk),
    .rst_n     (rst_n),
    .not_susp  (mode_q),
    .level     (level_q),
    .pend      (pend_q),
    .rx_dma_en (rx_dma_en),
    .tx_dma_en (tx_dma_en),
    .irq_req   (irq_req),
    .irq_src   (irq_src),
    .rx_dma_req(rx_dma_req),
    .tx_dma_req(tx_dma_req)
  );

  assign irq_level = level_q;

  p_err_held_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_enable && (|err_flags)) |=> reg_rd_data[BIT_ERR]);
  p_reset_mode_r1: assert property (@(posedge clk)
    !rst_n |=> (reg_rd_data == 8'h80));

endmodule

// File: tb/sbus_irq_arbiter_test.sv
module sbus_irq_arbiter_test;

  localparam int ERR_W = 8;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             reg_wr_en;
  logic [7:0]       reg_wr_data;
  logic [7:0]       reg_rd_data;
  logic [ERR_W-1:0] err_flags;
  logic             rx_data_evt, rx_eob_evt, tx_ready_evt, tx_eob_evt;
  logic             irq_enable, rx_dma_en, tx_dma_en;
  logic             irq_req;
  logic [2:0]       irq_level;
  logic [1:0]       irq_src;
  logic             rx_dma_req, tx_dma_req;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  // reference state
  logic       m_mode;
  logic [2:0] m_lvl;
  logic       m_e, m_r, m_t;

  always #2 clk = ~clk;

  sbus_irq_arbiter #(.ERR_W(ERR_W)) uut (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Expected outputs from ranks: index 0..4 = err, rxdma, txdma, rxirq, txirq
  task automatic expect_out(output logic e_irq, output logic [1:0] e_src,
                            output logic e_rxd, output logic e_txd);
    bit cand [5];
    int rank [5];
    int best;
    cand[0] = m_e;
    cand[1] = rx_dma_en && m_r && (m_mode || !m_e);
    cand[2] = tx_dma_en && m_t && (m_mode || !m_e);
    cand[3] = !rx_dma_en && m_r;
    cand[4] = !tx_dma_en && m_t;
    if (m_mode) rank = '{2, 0, 1, 3, 4};
    else        rank = '{0, 1, 2, 3, 4};
    best = -1;
    for (int i = 0; i < 5; i++)
      if (cand[i] && (best < 0 || rank[i] < rank[best])) best = i;
    e_rxd = (best == 1);
    e_txd = (best == 2);
    e_irq = (best == 0 || best == 3 || best == 4) && (m_lvl != 3'd7);
    e_src = !e_irq ? 2'b00 : (best == 0) ? 2'b01 : (best == 3) ? 2'b10 : 2'b11;
  endtask

  task automatic check_all();
    logic e_irq, e_rxd, e_txd;
    logic [1:0] e_src;
    logic [7:0] e_rd;
    e_rd = {m_mode, m_lvl, 1'b0, m_e, m_r, m_t};
    expect_out(e_irq, e_src, e_rxd, e_txd);
    chk(reg_rd_data == e_rd, "R2/R3 register", reg_rd_data, e_rd);
    chk(irq_level == m_lvl, "R10 level", irq_level, m_lvl);
    chk({irq_req, irq_src} == {e_irq, e_src}, "R11 irq", {irq_req, irq_src}, {e_irq, e_src});
    chk({rx_dma_req, tx_dma_req} == {e_rxd, e_txd}, m_mode ? "R8 dma" : "R7 dma",
        {rx_dma_req, tx_dma_req}, {e_rxd, e_txd});
  endtask

  // Advance one clock: model the edge from the driven inputs, then check.
  task automatic tick();
    logic n_mode, n_e, n_r, n_t;
    logic [2:0] n_lvl;
    bit se, sr, st;
    se = irq_enable && (err_flags != 0);
    sr = irq_enable && (rx_data_evt || rx_eob_evt);
    st = irq_enable && (tx_ready_evt || tx_eob_evt);
    n_mode = reg_wr_en ? reg_wr_data[7]   : m_mode;
    n_lvl  = reg_wr_en ? reg_wr_data[6:4] : m_lvl;
    n_e = se ? 1'b1 : (reg_wr_en && !reg_wr_data[2]) ? 1'b0 : m_e;
    n_r = sr ? 1'b1 : (reg_wr_en && !reg_wr_data[1]) ? 1'b0 : m_r;
    n_t = st ? 1'b1 : (reg_wr_en && !reg_wr_data[0]) ? 1'b0 : m_t;
    @(posedge clk);
    @(negedge clk);
    m_mode = n_mode; m_lvl = n_lvl; m_e = n_e; m_r = n_r; m_t = n_t;
    check_all();
  endtask

  task automatic idle_inputs();
    reg_wr_en = 0; reg_wr_data = 0; err_flags = 0;
    rx_data_evt = 0; rx_eob_evt = 0; tx_ready_evt = 0; tx_eob_evt = 0;
  endtask

  task automatic wr(input logic [7:0] d);
    reg_wr_en = 1; reg_wr_data = d;
  endtask

  initial begin
    #800000;
    if (!done) begin
      n_fail++; n_tests++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int unused_seed;
    unused_seed = $urandom(32'd20240611);
    rst_n = 0; idle_inputs();
    irq_enable = 1; rx_dma_en = 0; tx_dma_en = 0;
    err_flags = 8'h01; rx_data_evt = 1;   // events during reset must not stick
    repeat (3) @(posedge clk);
    @(negedge clk);
    m_mode = 1; m_lvl = 0; m_e = 0; m_r = 0; m_t = 0;
    // R1: reset state
    chk(reg_rd_data == 8'h80, "R1 reset reg", reg_rd_data, 8'h80);
    chk({irq_req, rx_dma_req, tx_dma_req} == 3'b000, "R1 reset outs",
        {irq_req, rx_dma_req, tx_dma_req}, 0);
    idle_inputs();
    rst_n = 1;
    tick();

    // R2: reserved bit ignored, mode and level loaded
    wr(8'h3F); tick(); idle_inputs();
    chk(reg_rd_data == 8'h30, "R2 rsvd", reg_rd_data, 8'h30);

    // R4: no set with irq_enable low
    irq_enable = 0; err_flags = 8'h80; rx_eob_evt = 1; tx_ready_evt = 1; tick();
    idle_inputs();
    chk(reg_rd_data[2:0] == 3'b000, "R4 gated", reg_rd_data[2:0], 0);
    irq_enable = 1; rx_eob_evt = 1; tx_eob_evt = 1; tick(); idle_inputs();
    chk(reg_rd_data[1:0] == 2'b11, "R4 eob set", reg_rd_data[1:0], 3);

    // R3: write 1 keeps, write 0 clears only its bit; R11 tx code
    wr(8'h3E); tick(); idle_inputs();
    chk(reg_rd_data[1:0] == 2'b10, "R3 clear tx only", reg_rd_data[1:0], 2);
    wr(8'h35); tick(); idle_inputs();
    chk(reg_rd_data[2:0] == 3'b000, "R3 one no set", reg_rd_data[2:0], 0);

    // R5: set beats clear
    rx_data_evt = 1; wr(8'h30); tick(); idle_inputs();
    chk(reg_rd_data[1] == 1'b1, "R5 set wins", reg_rd_data[1], 1);
    chk(irq_src == 2'b10, "R11 rx code", irq_src, 2);

    // R6: error held while flag present
    err_flags = 8'h10; tick();
    wr(8'h30); tick();
    chk(reg_rd_data[2] == 1'b1, "R6 held", reg_rd_data[2], 1);
    chk(irq_src == 2'b01, "R11 err code", irq_src, 1);
    err_flags = 0; wr(8'h30); tick(); idle_inputs();
    chk(reg_rd_data[2] == 1'b0, "R6 released", reg_rd_data[2], 0);

    // R7 / R8: error with rx DMA in both modes
    rx_dma_en = 1; err_flags = 8'h02; rx_data_evt = 1; wr(8'h30); tick(); idle_inputs();
    chk(rx_dma_req == 1'b0 && irq_src == 2'b01, "R7 suspend", {rx_dma_req, irq_src}, 1);
    wr(8'hB7); tick(); idle_inputs();
    chk(rx_dma_req == 1'b1 && irq_req == 1'b0, "R8 dma first", {rx_dma_req, irq_req}, 2);

    // R9: tx interrupt waits behind rx DMA
    tx_ready_evt = 1; tick(); idle_inputs();
    chk(tx_dma_req == 0 && irq_req == 0, "R9 single winner", {tx_dma_req, irq_req}, 0);

    // R10: level 7 mutes the interrupt, not DMA
    rx_dma_en = 0; wr(8'hF7); tick(); idle_inputs();
    chk(irq_req == 1'b0 && irq_level == 3'd7, "R10 mute", {irq_req, irq_level}, 7);
    rx_dma_en = 1; tick();
    chk(rx_dma_req == 1'b1, "R10 dma unmuted", rx_dma_req, 1);

    // random phase
    for (int c = 0; c < 4000; c++) begin
      idle_inputs();
      if ($urandom_range(0, 4) == 0) begin
        reg_wr_en = 1; reg_wr_data = 8'($urandom);
      end
      if ($urandom_range(0, 5) == 0) err_flags = 8'($urandom);
      rx_data_evt  = ($urandom_range(0, 5) == 0);
      rx_eob_evt   = ($urandom_range(0, 9) == 0);
      tx_ready_evt = ($urandom_range(0, 5) == 0);
      tx_eob_evt   = ($urandom_range(0, 9) == 0);
      if ($urandom_range(0, 15) == 0) irq_enable = ~irq_enable;
      if ($urandom_range(0, 7) == 0) rx_dma_en = $urandom_range(0, 1);
      if ($urandom_range(0, 7) == 0) tx_dma_en = $urandom_range(0, 1);
      tick();
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule